// File: doc/BRIEF.md
# Dynamic Bus Sizing Controller

This block is a bus-master sequencer. It takes one internal transfer request of one to four bytes, read or write, at any byte address. It turns that request into as many external bus cycles as the addressed device needs. The device states its port width (32, 16 or 8 bits) on the acknowledge inputs of every cycle. After each cycle the controller moves the address forward by the bytes just moved, lowers the remaining count by the same amount, and starts another cycle until the operand is complete. Byte order is big-endian: the operand's most significant byte belongs to the lowest address.

The internal side is two valid/ready channels. A request is taken on a clock where `req_valid` and `req_ready` are both high. `req_ready` stays low from then on until the response has been taken. The response is offered with `rsp_valid` and holds its data and error flag unchanged while `rsp_ready` is low. Only one transfer is in flight at a time, so a stalled response also stalls the request channel. The external side uses separate address and data buses, address and data strobes, a read/write line, a size code, a two-bit acknowledge and a bus-error input.

Top module: `dyn_bus_sizer`

## Requirements
- R1: `req_ready` is high only while the controller is idle. A request taken with `req_valid` high puts its address on `bus_addr` with both strobes asserted on the next clock, and `req_ready` stays low until the response is taken.
- R2: The size code on `req_size` and `bus_size` is 01 = 1 byte, 10 = 2 bytes, 11 = 3 bytes, 00 = 4 bytes. During each cycle `bus_size` shows the bytes still to move.
- R3: The acknowledge code on `bus_ack` is 00 = 32-bit port, 01 = 16-bit port, 10 = 8-bit port and 11 = not terminated. While the code is 11, the cycle continues with address, size and strobes unchanged.
- R4: A terminated cycle moves min(remaining, W - offset) bytes. Here W is the port width in bytes and offset is the address modulo W. The strobes drop for exactly one clock, and the next cycle starts at the advanced address. The number of cycles per transfer follows from this rule.
- R5: For a write, the most significant remaining byte is denoted B0, followed by B1, B2 and B3. `bus_dout` lanes [31:24],[23:16],[15:8],[7:0] then carry: offset 0 → B0 B1 B2 B3; offset 1 → B0 B0 B1 B2; offset 2 → B0 B1 B0 B1; offset 3 → B0 B0 B1 B0. This lets every port width find its bytes.
- R6: For a read, the bytes are taken from the lanes given by the port width and offset: lane = offset for 32-bit ports, offset modulo 2 for 16-bit ports, lane 0 (bits 31:24) for 8-bit ports. The bytes are gathered into `rsp_rdata` right-justified with unused upper bits zero. `rsp_rdata` is zero for writes.
- R7: `bus_err` high during a cycle ends the transfer with no further cycles. The response then carries `rsp_error` = 1 and `rsp_rdata` = 0, discarding bytes already gathered.
- R8: While `rsp_valid` is high and `rsp_ready` is low, the response and its data and error flag stay unchanged.
- R9: After reset the controller is idle, with `req_ready` high, both strobes low and `rsp_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Operand size code |
| req_addr | input | ADDR_W | Byte address of operand |
| req_wdata | input | 32 | Write operand, right-justified |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Response taken when high with rsp_valid |
| rsp_rdata | output | 32 | Read operand, right-justified |
| rsp_error | output | 1 | Transfer ended by bus error |
| bus_addr | output | ADDR_W | Current cycle address |
| bus_size | output | 2 | Remaining bytes code |
| bus_rnw | output | 1 | 1 = read cycle, 0 = write cycle |
| bus_as | output | 1 | Address strobe |
| bus_ds | output | 1 | Data strobe |
| bus_dout | output | 32 | Write data lanes |
| bus_din | input | 32 | Read data lanes |
| bus_ack | input | 2 | Port width / termination code |
| bus_err | input | 1 | Bus error |

## Verification
The bench builds the block with ADDR_W = 16. Its device model decodes address bits [5:4]: one region is a 32-bit port, one a 16-bit port, one an 8-bit port, and the last answers every cycle with a bus error. This puts every port width and every byte offset within reach. It also reaches a long read that crosses from the 8-bit region into the error region and fails on its third cycle. A variable count of wait clocks before each acknowledge exercises the wait code, and a withheld `rsp_ready` exercises back-pressure.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  localparam int DBS_LANES  = 4;
  localparam int DBS_LANE_W = 8;
  localparam int DBS_DATA_W = DBS_LANES * DBS_LANE_W;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CYC  = 2'd1,
    ST_GAP  = 2'd2,
    ST_RESP = 2'd3
  } dbs_state_e;

  localparam logic [1:0] ACK_WAIT = 2'b11;

  // bytes a port of the reported width carries; 0 while not terminated
  function automatic logic [2:0] port_bytes(input logic [1:0] ack);
    case (ack)
      2'b00:   return 3'd4;
      2'b01:   return 3'd2;
      2'b10:   return 3'd1;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [2:0] code_to_count(input logic [1:0] code);
    return (code == 2'b00) ? 3'd4 : {1'b0, code};
  endfunction
endpackage

// File: rtl/dbs_step.sv
module dbs_step
  import dbs_pkg::*;
(
  input  logic [1:0] addr_lo,
  input  logic [2:0] remain,
  input  logic [1:0] ack,
  output logic [2:0] take,
  output logic [1:0] lane
);
  logic [2:0] width;
  logic [2:0] room;

  always_comb begin
    width = port_bytes(ack);
    case (width)
      3'd4:    lane = addr_lo;
      3'd2:    lane = {1'b0, addr_lo[0]};
      default: lane = 2'd0;
    endcase
    room = width - {1'b0, lane};
    take = (remain < room) ? remain : room;
  end
endmodule

// File: rtl/dbs_wr_lanes.sv
module dbs_wr_lanes
  import dbs_pkg::*;
(
  input  logic [DBS_DATA_W-1:0] opd,
  input  logic [1:0]            addr_lo,
  output logic [DBS_DATA_W-1:0] lanes_out
);
  logic [DBS_LANE_W-1:0] b [DBS_LANES];

  for (genvar g = 0; g < DBS_LANES; g++) begin : g_split
    assign b[g] = opd[DBS_DATA_W-1-g*DBS_LANE_W -: DBS_LANE_W];
  end

  always_comb begin
    case (addr_lo)
      2'd0:    lanes_out = {b[0], b[1], b[2], b[3]};
      2'd1:    lanes_out = {b[0], b[0], b[1], b[2]};
      2'd2:    lanes_out = {b[0], b[1], b[0], b[1]};
      default: lanes_out = {b[0], b[0], b[1], b[0]};
    endcase
  end
endmodule

// File: rtl/dbs_rd_pack.sv
module dbs_rd_pack
  import dbs_pkg::*;
(
  input  logic [DBS_DATA_W-1:0] acc,
  input  logic [DBS_DATA_W-1:0] din,
  input  logic [1:0]            lane,
  input  logic [2:0]            take,
  output logic [DBS_DATA_W-1:0] acc_next
);
  logic [DBS_DATA_W-1:0] aligned;
  logic [DBS_DATA_W-1:0] fresh;
  logic [5:0]            drop;

  always_comb begin
    aligned = din << {lane, 3'b000};
    drop    = 6'd32 - {take, 3'b000};
    fresh   = (take == 3'd0) ? '0 : (aligned >> drop);
    if (take == 3'd4) acc_next = fresh;
    else              acc_next = (acc << {take, 3'b000}) | fresh;
  end
endmodule

// File: rtl/dyn_bus_sizer.sv
module dyn_bus_sizer
  import dbs_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [1:0]            req_size,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DBS_DATA_W-1:0] req_wdata,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [DBS_DATA_W-1:0] rsp_rdata,
  output logic                  rsp_error,
  output logic [ADDR_W-1:0]     bus_addr,
  output logic [1:0]            bus_size,
  output logic                  bus_rnw,
  output logic                  bus_as,
  output logic                  bus_ds,
  output logic [DBS_DATA_W-1:0] bus_dout,
  input  logic [DBS_DATA_W-1:0] bus_din,
  input  logic [1:0]            bus_ack,
  input  logic                  bus_err
);
  dbs_state_e            state;
  logic [ADDR_W-1:0]     addr_q;
  logic [2:0]            rem_q;
  logic [DBS_DATA_W-1:0] opd_q;
  logic [DBS_DATA_W-1:0] acc_q;
  logic                  wr_q;
  logic                  err_q;

  logic [2:0]            take;
  logic [1:0]            lane;
  logic [DBS_DATA_W-1:0] acc_next;
  logic [DBS_DATA_W-1:0] lanes_out;
  logic [2:0]            req_cnt;

  assign req_cnt = code_to_count(req_size);

  dbs_step u_step (
    .addr_lo (addr_q[1:0]),
    .remain  (rem_q),
    .ack     (bus_ack),
    .take    (take),
    .lane    (lane)
  );

  dbs_wr_lanes u_wr (
    .opd       (opd_q),
    .addr_lo   (addr_q[1:0]),
    .lanes_out (lanes_out)
  );

  dbs_rd_pack u_rd (
    .acc      (acc_q),
    .din      (bus_din),
    .lane     (lane),
    .take     (take),
    .acc_next (acc_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      addr_q <= '0;
      rem_q  <= '0;
      opd_q  <= '0;
      acc_q  <= '0;
      wr_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          state  <= ST_CYC;
          addr_q <= req_addr;
          rem_q  <= req_cnt;
          opd_q  <= req_wdata << {3'd4 - req_cnt, 3'b000};
          acc_q  <= '0;
          wr_q   <= req_write;
          err_q  <= 1'b0;
        end
        ST_CYC: begin
          if (bus_err) begin
            state <= ST_RESP;
            err_q <= 1'b1;
            acc_q <= '0;
          end else if (take != 3'd0) begin
            addr_q <= addr_q + ADDR_W'(take);
            rem_q  <= rem_q - take;
            opd_q  <= opd_q << {take, 3'b000};
            if (!wr_q) acc_q <= acc_next;
            state  <= (rem_q == take) ? ST_RESP : ST_GAP;
          end
        end
        ST_GAP:  state <= ST_CYC;
        default: if (rsp_ready) state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign rsp_valid = (state == ST_RESP);
  assign rsp_rdata = acc_q;
  assign rsp_error = err_q;
  assign bus_addr  = addr_q;
  assign bus_size  = rem_q[1:0];
  assign bus_rnw   = !wr_q;
  assign bus_as    = (state == ST_CYC);
  assign bus_ds    = (state == ST_CYC);
  assign bus_dout  = wr_q ? lanes_out : '0;

  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (bus_as && bus_ds && bus_addr == $past(req_addr))); // R1
  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_as && bus_ack == ACK_WAIT && !bus_err) |=> (bus_as && $stable(bus_addr) && $stable(bus_size))); // R3
  AST_STROBE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_as && bus_ack != ACK_WAIT && !bus_err) |=> !bus_as); // R4
  AST_ERR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_as && bus_err) |=> (!bus_as && rsp_valid && rsp_error && rsp_rdata == '0)); // R7
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_error))); // R8
endmodule

// File: tb/sim_dyn_bus_sizer.sv
`timescale 1ns/1ps
module sim_dyn_bus_sizer;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_ready, req_write;
  logic [1:0]    req_size;
  logic [AW-1:0] req_addr;
  logic [31:0]   req_wdata;
  logic          rsp_valid, rsp_ready, rsp_error;
  logic [31:0]   rsp_rdata;
  logic [AW-1:0] bus_addr;
  logic [1:0]    bus_size;
  logic          bus_rnw, bus_as, bus_ds;
  logic [31:0]   bus_dout;
  logic [31:0]   bus_din;
  logic [1:0]    bus_ack;
  logic          bus_err;

  always #10 clk = ~clk;

  dyn_bus_sizer #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_error(rsp_error),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_rnw(bus_rnw),
    .bus_as(bus_as), .bus_ds(bus_ds), .bus_dout(bus_dout), .bus_din(bus_din),
    .bus_ack(bus_ack), .bus_err(bus_err)
  );

  typedef struct {
    logic [31:0] data;
    logic        err;
    int          cycles;
    logic [1:0]  size;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [7:0]  dev  [64];
  logic [7:0]  refm [64];
  int checks = 0;
  int errs   = 0;
  int nwait  = 0;
  int waitc  = 0;
  int cyc_cnt = 0;
  logic [1:0] first_size;
  logic prev_as = 1'b0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // device model: region by address bits [5:4]: 0 = 32-bit, 1 = 16-bit, 2 = 8-bit, 3 = bus error
  always @(negedge clk) begin
    int a, p, base, lane0, cnt, k;
    logic [31:0] d;
    if (!rst_n || !bus_as) begin
      bus_ack <= 2'b11;
      bus_err <= 1'b0;
      waitc = 0;
    end else if (bus_ack == 2'b11 && !bus_err) begin
      if (waitc < nwait) waitc++;
      else if (bus_addr[5:4] == 2'd3) bus_err <= 1'b1;
      else begin
        p = (bus_addr[5:4] == 2'd0) ? 4 : (bus_addr[5:4] == 2'd1) ? 2 : 1;
        bus_ack <= (p == 4) ? 2'b00 : (p == 2) ? 2'b01 : 2'b10;
        a = int'(bus_addr[5:0]);
        base = a - (a % p);
        lane0 = a - base;
        cnt = (bus_size == 2'b00) ? 4 : int'(bus_size);
        k = (cnt < p - lane0) ? cnt : p - lane0;
        if (!bus_rnw) begin
          for (int i = 0; i < k; i++) dev[(a + i) % 64] = bus_dout[31 - 8*(lane0 + i) -: 8];
        end else begin
          d = 32'hEEEE_EEEE;
          for (int j = 0; j < p; j++) d[31 - 8*j -: 8] = dev[base + j];
          bus_din <= d;
        end
      end
    end
  end

  // monitor: counts bus cycles and scores responses
  always @(negedge clk) begin
    exp_t e;
    if (bus_as && !prev_as) begin
      cyc_cnt++;
      if (cyc_cnt == 1) first_size = bus_size;
    end
    prev_as = bus_as;
    if (rst_n && rsp_valid && rsp_ready) begin
      if (sb.size() == 0) check(1'b0, "R1", "unexpected response", 32'd1, 32'd0);
      else begin
        e = sb.pop_front();
        check(rsp_rdata == e.data, e.tag, "rdata", rsp_rdata, e.data);
        check(rsp_error == e.err, "R7", "error flag", 32'(rsp_error), 32'(e.err));
        check(cyc_cnt == e.cycles, "R4", "bus cycle count", 32'(cyc_cnt), 32'(e.cycles));
        check(first_size == e.size, "R2", "first size code", 32'(first_size), 32'(e.size));
      end
    end
  end

  task automatic txn(input bit wr, input logic [1:0] sz, input logic [5:0] ad,
                     input logic [31:0] wd, input string tag, input bit hold_rsp);
    exp_t e;
    int n, a, rem, p, k, idx;
    n = (sz == 2'b00) ? 4 : int'(sz);
    e.data = '0; e.err = 1'b0; e.cycles = 0; e.size = sz; e.tag = tag;
    a = int'(ad); rem = n; idx = 0;
    while (rem > 0) begin
      e.cycles++;
      if (((a >> 4) & 3) == 3) begin e.err = 1'b1; break; end
      p = (((a >> 4) & 3) == 0) ? 4 : (((a >> 4) & 3) == 1) ? 2 : 1;
      k = (rem < p - (a % p)) ? rem : p - (a % p);
      for (int i = 0; i < k; i++) begin
        if (wr) refm[(a + i) % 64] = wd[8*(n - 1 - idx) +: 8];
        else    e.data = (e.data << 8) | 32'(refm[(a + i) % 64]);
        idx++;
      end
      a += k; rem -= k;
    end
    if (wr || e.err) e.data = '0;
    sb.push_back(e);

    @(negedge clk);
    cyc_cnt = 0;
    check(req_ready == 1'b1, "R1", "ready before request", 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_write = wr; req_size = sz;
    req_addr = AW'(ad); req_wdata = wd;
    if (hold_rsp) rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R1", "ready after accept", 32'(req_ready), 32'd0);
    if (hold_rsp) begin
      logic [31:0] held;
      while (!rsp_valid) @(negedge clk);
      held = rsp_rdata;
      repeat (4) @(negedge clk);
      check(rsp_valid == 1'b1, "R8", "valid held under back-pressure", 32'(rsp_valid), 32'd1);
      check(rsp_rdata == held, "R8", "data stable under back-pressure", rsp_rdata, held);
      check(req_ready == 1'b0, "R1", "ready low while response pending", 32'(req_ready), 32'd0);
      rsp_ready = 1'b1;
    end
    while (sb.size() != 0) @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errs++;
      $display("FAIL R4 watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      dev[i]  = 8'(i * 7 + 3);
      refm[i] = 8'(i * 7 + 3);
    end
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_size = 2'b00;
    req_addr = '0; req_wdata = '0; rsp_ready = 1'b1; bus_din = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R9", "reset ready", 32'(req_ready), 32'd1);
    check(bus_as == 1'b0 && bus_ds == 1'b0, "R9", "reset strobes", 32'(bus_as), 32'd0);
    check(rsp_valid == 1'b0, "R9", "reset rsp_valid", 32'(rsp_valid), 32'd0);

    txn(0, 2'b00, 6'h00, 0, "R6", 0);            // aligned long, 32-bit port
    txn(0, 2'b00, 6'h01, 0, "R4/R6", 0);         // unaligned long, 32-bit port
    txn(0, 2'b00, 6'h11, 0, "R4/R6", 0);         // long on 16-bit port
    txn(0, 2'b00, 6'h20, 0, "R4/R6", 0);         // long on 8-bit port
    txn(0, 2'b11, 6'h13, 0, "R2/R6", 0);         // three bytes, 16-bit port
    txn(1, 2'b10, 6'h23, 32'h0000_A1B2, "R5", 0);
    txn(0, 2'b10, 6'h23, 0, "R5", 0);
    txn(1, 2'b00, 6'h12, 32'hC3D4_E5F6, "R5", 0);
    txn(0, 2'b00, 6'h12, 0, "R5", 0);
    txn(1, 2'b11, 6'h05, 32'h0011_2233, "R5", 0);
    txn(1, 2'b01, 6'h0B, 32'h0000_0099, "R5", 0);
    txn(0, 2'b00, 6'h04, 0, "R5", 0);
    txn(0, 2'b00, 6'h08, 0, "R5", 0);
    nwait = 3;
    txn(0, 2'b00, 6'h1F, 0, "R3", 0);            // waits on a 16-bit port, crosses into 8-bit region
    txn(1, 2'b10, 6'h0E, 32'h0000_5A5A, "R3", 0);
    nwait = 0;
    txn(0, 2'b01, 6'h30, 0, "R7", 0);            // error on first cycle
    txn(1, 2'b00, 6'h34, 32'h1234_5678, "R7", 0);
    txn(0, 2'b00, 6'h2E, 0, "R7", 0);            // error on third cycle, partial data dropped
    txn(0, 2'b00, 6'h02, 0, "R8", 1);            // back-pressure on the response
    txn(0, 2'b10, 6'h0E, 0, "R3/R6", 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule